// File: doc/BRIEF.md
# Time-Multiplexed Timer Bus Arbiter

This block shares one internal time bus among up to four timers. A slot counter steps once per state-time tick and, in each step, grants the bus to the timer that owns the current slot. That timer's 16-bit value is placed on the bus together with a valid flag. The same timer also receives a one-cycle count-allowed strobe, so each timer can advance at most once per frame.

A one-bit frame mode, held in an 8-bit mode register, chooses between two frame lengths. The short frame has two slots, used by timers 0 and 1. The long frame has four slots, used by timers 0 to 3. With a tick every state time, a timer in the short frame may count once every two state times. In the long frame it may count once every four state times. In the short frame the upper two timers never receive a strobe.

A new mode written to the register takes effect only when the current frame ends. A frame is therefore never cut short or stretched partway through. The consumers of the bus, the capture and compare units, sit outside this block.

Top module: `tmr_bus_arb`

## Requirements
- R1: While `rst` is high, and after it is released until the first tick, `slot_idx` is 0, `bus_vld` is 0, `cnt_ok` is 0000, `bus_val` is 0 and `mode_rdata` is 00H. The effective frame is the short frame.
- R2: A cycle with `mode_wr` high stores `mode_wdata[0]` as the frame mode. From the next cycle, `mode_rdata` shows the stored bit in bit 0 and zeros in bits 7:1, whatever was written there. Mode value 0 selects the short two-slot frame; value 1 selects the long four-slot frame.
- R3: Each clock edge with `tick` high grants one slot. `slot_idx` shows that slot index from the following cycle. Successive grants step 0,1,0,1 in the short frame and 0,1,2,3,0 in the long frame. A cycle without `tick` leaves the slot sequence where it is, and `slot_idx` and `bus_val` hold their values.
- R4: After a grant, `bus_val` carries the value that the owning timer had at the granting edge. Timer n is bits [16n+15:16n] of `tmr_vals`. `bus_vld` is high for exactly the one cycle following each grant.
- R5: `cnt_ok` is one-hot, with bit n equal to slot n, during the cycle following a grant, and all zero in every other cycle.
- R6: While the short frame is in effect, `cnt_ok[3:2]` stay 0 and `slot_idx` never exceeds 1.
- R7: A mode change takes effect only after the last slot of the frame that is in progress is granted. The remaining grants of that frame follow the old frame length.
- R8: With a tick on every cycle, over 8 consecutive grants each timer receives 4 strobes in the short frame (timers 0 and 1) or 2 strobes in the long frame (timers 0 to 3). At most one strobe per timer falls in each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 8 | Mode write data; only bit 0 is kept |
| tick | input | 1 | State-time tick; one slot grant per high cycle |
| tmr_vals | input | 64 | Four packed 16-bit timer values, timer n in bits [16n+15:16n] |
| slot_idx | output | 2 | Index of the most recently granted slot |
| bus_val | output | 16 | Time bus value of the granted timer |
| bus_vld | output | 1 | Bus transfer valid, one cycle per grant |
| cnt_ok | output | 4 | Per-timer count-allowed strobe |
| mode_rdata | output | 8 | Mode register read value |

## Verification
A wrong slot counter shows at the ports one cycle after the next tick. It appears either as a `slot_idx` outside the expected step sequence or as a strobe and bus value that belong to another timer. An effective mode that switches at the wrong time shows at the first grant after the write: a slot 0 appears where slot 2 was due, or slot 2 appears in a short frame. Strobe-count windows over eight grants expose rate errors. A reset taken in the middle of a run, in long-frame mode, confirms that the state and the mode return to their start values within one cycle.

// File: rtl/tba_pkg.sv
package tba_pkg;
  localparam int unsigned TBA_MODE_W = 8;

  typedef enum logic {
    FRAME_SHORT = 1'b0,
    FRAME_LONG  = 1'b1
  } frame_e;
endpackage

// File: rtl/tba_mode_reg.sv
module tba_mode_reg
  import tba_pkg::*;
#(
  parameter int unsigned MODE_W = TBA_MODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  output frame_e            mode_sel,
  output logic [MODE_W-1:0] rd_data
);
  frame_e mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= FRAME_SHORT;
    end else if (wr_en) begin
      mode_q <= frame_e'(wr_data[0]);
    end
  end

  assign mode_sel = mode_q;
  assign rd_data  = {{(MODE_W-1){1'b0}}, mode_q};

  // Upper write bits are reserved and intentionally dropped.
  logic unused_hi;
  assign unused_hi = ^wr_data[MODE_W-1:1];
endmodule

// File: rtl/tba_slot_seq.sv
module tba_slot_seq
  import tba_pkg::*;
#(
  parameter int unsigned SHORT_SLOTS = 2,
  parameter int unsigned LONG_SLOTS  = 4,
  parameter int unsigned SLOT_W      = $clog2(LONG_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  frame_e            req_mode,
  output logic [SLOT_W-1:0] cur_slot,
  output frame_e            eff_mode
);
  localparam logic [SLOT_W-1:0] SHORT_LAST = SLOT_W'(SHORT_SLOTS - 1);
  localparam logic [SLOT_W-1:0] LONG_LAST  = SLOT_W'(LONG_SLOTS - 1);

  logic [SLOT_W-1:0] slot_q;
  frame_e            eff_q;
  logic [SLOT_W-1:0] last_slot;
  logic              at_end;

  always_comb begin
    last_slot = (eff_q == FRAME_LONG) ? LONG_LAST : SHORT_LAST;
    at_end    = (slot_q == last_slot);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      eff_q  <= FRAME_SHORT;
    end else if (tick) begin
      if (at_end) begin
        slot_q <= '0;
        eff_q  <= req_mode;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  assign cur_slot = slot_q;
  assign eff_mode = eff_q;
endmodule

// File: rtl/tba_bus_mux.sv
module tba_bus_mux #(
  parameter int unsigned NUM_TMR = 4,
  parameter int unsigned TMR_W   = 16,
  parameter int unsigned SLOT_W  = $clog2(NUM_TMR)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     grant,
  input  logic [SLOT_W-1:0]        sel,
  input  logic [NUM_TMR*TMR_W-1:0] tmr_flat,
  output logic [TMR_W-1:0]         bus_val,
  output logic                     bus_vld,
  output logic [SLOT_W-1:0]        slot_out
);
  logic [TMR_W-1:0] vals [NUM_TMR];

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_unpack
    assign vals[g] = tmr_flat[g*TMR_W +: TMR_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_val  <= '0;
      bus_vld  <= 1'b0;
      slot_out <= '0;
    end else begin
      bus_vld <= grant;
      if (grant) begin
        bus_val  <= vals[sel];
        slot_out <= sel;
      end
    end
  end
endmodule

// File: rtl/tba_strobe_dec.sv
module tba_strobe_dec #(
  parameter int unsigned NUM_TMR = 4,
  parameter int unsigned SLOT_W  = $clog2(NUM_TMR)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               grant,
  input  logic [SLOT_W-1:0]  sel,
  output logic [NUM_TMR-1:0] cnt_ok
);
  for (genvar g = 0; g < NUM_TMR; g++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_ok[g] <= 1'b0;
      end else begin
        cnt_ok[g] <= grant && (sel == SLOT_W'(g));
      end
    end
  end
endmodule

// File: rtl/tmr_bus_arb.sv
module tmr_bus_arb
  import tba_pkg::*;
#(
  parameter int unsigned TMR_W       = 16,
  parameter int unsigned SHORT_SLOTS = 2,
  parameter int unsigned LONG_SLOTS  = 4,
  parameter int unsigned MODE_W      = TBA_MODE_W,
  localparam int unsigned NUM_TMR    = LONG_SLOTS,
  localparam int unsigned SLOT_W     = $clog2(LONG_SLOTS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mode_wr,
  input  logic [MODE_W-1:0]        mode_wdata,
  input  logic                     tick,
  input  logic [NUM_TMR*TMR_W-1:0] tmr_vals,
  output logic [SLOT_W-1:0]        slot_idx,
  output logic [TMR_W-1:0]         bus_val,
  output logic                     bus_vld,
  output logic [NUM_TMR-1:0]       cnt_ok,
  output logic [MODE_W-1:0]        mode_rdata
);
  frame_e            req_mode;
  frame_e            eff_mode;
  logic [SLOT_W-1:0] cur_slot;

  tba_mode_reg #(.MODE_W(MODE_W)) u_mode (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (mode_wr),
    .wr_data  (mode_wdata),
    .mode_sel (req_mode),
    .rd_data  (mode_rdata)
  );

  tba_slot_seq #(
    .SHORT_SLOTS (SHORT_SLOTS),
    .LONG_SLOTS  (LONG_SLOTS),
    .SLOT_W      (SLOT_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .req_mode (req_mode),
    .cur_slot (cur_slot),
    .eff_mode (eff_mode)
  );

  tba_bus_mux #(
    .NUM_TMR (NUM_TMR),
    .TMR_W   (TMR_W),
    .SLOT_W  (SLOT_W)
  ) u_mux (
    .clk      (clk),
    .rst      (rst),
    .grant    (tick),
    .sel      (cur_slot),
    .tmr_flat (tmr_vals),
    .bus_val  (bus_val),
    .bus_vld  (bus_vld),
    .slot_out (slot_idx)
  );

  tba_strobe_dec #(
    .NUM_TMR (NUM_TMR),
    .SLOT_W  (SLOT_W)
  ) u_dec (
    .clk    (clk),
    .rst    (rst),
    .grant  (tick),
    .sel    (cur_slot),
    .cnt_ok (cnt_ok)
  );
endmodule

// File: rtl/tmr_bus_arb_chk.sv
module tmr_bus_arb_chk
  import tba_pkg::*;
#(
  parameter int unsigned NUM_TMR     = 4,
  parameter int unsigned SHORT_SLOTS = 2,
  parameter int unsigned SLOT_W      = 2,
  parameter int unsigned MODE_W      = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [SLOT_W-1:0]  slot_idx,
  input logic               bus_vld,
  input logic [NUM_TMR-1:0] cnt_ok,
  input logic [MODE_W-1:0]  mode_rdata,
  input frame_e             eff_mode
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R1: state right after reset
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    !past_ok |-> (slot_idx == '0 && !bus_vld && cnt_ok == '0 && mode_rdata == '0));

  // R2: reserved mode bits read as zero
  assert_mode_hi_zero_R2: assert property (@(posedge clk) disable iff (rst)
    mode_rdata[MODE_W-1:1] == '0);

  // R3: consecutive grants step by one or wrap to zero
  assert_slot_step_R3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && bus_vld && $past(bus_vld)) |->
      (slot_idx == $past(slot_idx) + 1'b1 || slot_idx == '0));

  // R3: no grant, slot index holds
  assert_slot_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !bus_vld) |-> $stable(slot_idx));

  // R5: strobes one-hot and tied to the valid flag and slot
  assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cnt_ok));
  assert_strobe_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !bus_vld |-> cnt_ok == '0);
  assert_strobe_match_R5: assert property (@(posedge clk) disable iff (rst)
    bus_vld |-> cnt_ok[slot_idx]);

  // R6: upper strobes only when the long frame was in effect at the grant
  assert_short_upper_low_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && (|cnt_ok[NUM_TMR-1:SHORT_SLOTS])) |-> $past(eff_mode) == FRAME_LONG);
endmodule

bind tmr_bus_arb tmr_bus_arb_chk #(
  .NUM_TMR     (NUM_TMR),
  .SHORT_SLOTS (SHORT_SLOTS),
  .SLOT_W      (SLOT_W),
  .MODE_W      (MODE_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .slot_idx   (slot_idx),
  .bus_vld    (bus_vld),
  .cnt_ok     (cnt_ok),
  .mode_rdata (mode_rdata),
  .eff_mode   (eff_mode)
);

// File: tb/test_tmr_bus_arb.sv
module test_tmr_bus_arb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_wr = 1'b0;
  logic [7:0]  mode_wdata = '0;
  logic        tick = 1'b0;
  logic [63:0] tmr_vals;
  logic [1:0]  slot_idx;
  logic [15:0] bus_val;
  logic        bus_vld;
  logic [3:0]  cnt_ok;
  logic [7:0]  mode_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  tmr_bus_arb i_tmr_bus_arb (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .tick(tick), .tmr_vals(tmr_vals), .slot_idx(slot_idx), .bus_val(bus_val),
    .bus_vld(bus_vld), .cnt_ok(cnt_ok), .mode_rdata(mode_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // {wr, wdata, tick, exp_slot, exp_vld, exp_cnt, exp_bus, exp_mode}
  localparam int NV = 17;
  localparam logic [40:0] TBL [NV] = '{
    {1'b0, 8'h00, 1'b1, 2'd0, 1'b1, 4'b0001, 16'hA001, 8'h00},
    {1'b0, 8'h00, 1'b1, 2'd1, 1'b1, 4'b0010, 16'hB002, 8'h00},
    {1'b0, 8'h00, 1'b0, 2'd1, 1'b0, 4'b0000, 16'hB002, 8'h00},
    {1'b1, 8'hFF, 1'b1, 2'd0, 1'b1, 4'b0001, 16'hA001, 8'h01},
    {1'b0, 8'h00, 1'b1, 2'd1, 1'b1, 4'b0010, 16'hB002, 8'h01},
    {1'b0, 8'h00, 1'b1, 2'd0, 1'b1, 4'b0001, 16'hA001, 8'h01},
    {1'b0, 8'h00, 1'b1, 2'd1, 1'b1, 4'b0010, 16'hB002, 8'h01},
    {1'b0, 8'h00, 1'b1, 2'd2, 1'b1, 4'b0100, 16'hC003, 8'h01},
    {1'b0, 8'h00, 1'b1, 2'd3, 1'b1, 4'b1000, 16'hD004, 8'h01},
    {1'b1, 8'h00, 1'b1, 2'd0, 1'b1, 4'b0001, 16'hA001, 8'h00},
    {1'b0, 8'h00, 1'b1, 2'd1, 1'b1, 4'b0010, 16'hB002, 8'h00},
    {1'b0, 8'h00, 1'b1, 2'd2, 1'b1, 4'b0100, 16'hC003, 8'h00},
    {1'b0, 8'h00, 1'b0, 2'd2, 1'b0, 4'b0000, 16'hC003, 8'h00},
    {1'b0, 8'h00, 1'b1, 2'd3, 1'b1, 4'b1000, 16'hD004, 8'h00},
    {1'b0, 8'h00, 1'b1, 2'd0, 1'b1, 4'b0001, 16'hA001, 8'h00},
    {1'b0, 8'h00, 1'b1, 2'd1, 1'b1, 4'b0010, 16'hB002, 8'h00},
    {1'b0, 8'h00, 1'b1, 2'd0, 1'b1, 4'b0001, 16'hA001, 8'h00}
  };

  task automatic run_ticks(input int n, output int c0, output int c1,
                           output int c2, output int c3);
    c0 = 0; c1 = 0; c2 = 0; c3 = 0;
    tick = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      c0 += int'(cnt_ok[0]); c1 += int'(cnt_ok[1]);
      c2 += int'(cnt_ok[2]); c3 += int'(cnt_ok[3]);
    end
    tick = 1'b0;
  endtask

  task automatic write_mode(input logic [7:0] v);
    mode_wr = 1'b1; mode_wdata = v;
    @(negedge clk);
    mode_wr = 1'b0; mode_wdata = '0;
  endtask

  initial begin
    int c0, c1, c2, c3;
    tmr_vals = {16'hD004, 16'hC003, 16'hB002, 16'hA001};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 slot", 32'(slot_idx), 0);
    chk("R1 vld", 32'(bus_vld), 0);
    chk("R1 cnt", 32'(cnt_ok), 0);
    chk("R1 bus", 32'(bus_val), 0);
    chk("R1 mode", 32'(mode_rdata), 0);

    // Table walk: R2 mode, R3 slot, R4 bus/valid, R5 strobes, R7 deferral (rows 9..13)
    for (int v = 0; v < NV; v++) begin
      mode_wr    = TBL[v][40];
      mode_wdata = TBL[v][39:32];
      tick       = TBL[v][31];
      @(negedge clk);
      chk($sformatf("R3 slot row %0d", v), 32'(slot_idx), 32'(TBL[v][30:29]));
      chk($sformatf("R4 vld row %0d", v),  32'(bus_vld),  32'(TBL[v][28]));
      chk($sformatf("R5 cnt row %0d", v),  32'(cnt_ok),   32'(TBL[v][27:24]));
      chk($sformatf("R4 bus row %0d", v),  32'(bus_val),  32'(TBL[v][23:8]));
      chk($sformatf("R2 mode row %0d", v), 32'(mode_rdata), 32'(TBL[v][7:0]));
    end
    mode_wr = 1'b0; mode_wdata = '0; tick = 1'b0;

    // R8 rate in both frames, R6 upper strobes silent, R7 deferral
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    write_mode(8'h01);
    run_ticks(2, c0, c1, c2, c3);           // finish the short frame
    chk("R7 short frame kept before boundary", 32'(c2 + c3), 0);
    run_ticks(8, c0, c1, c2, c3);
    chk("R8 long t0", 32'(c0), 2);
    chk("R8 long t1", 32'(c1), 2);
    chk("R8 long t2", 32'(c2), 2);
    chk("R8 long t3", 32'(c3), 2);
    write_mode(8'h00);
    run_ticks(3, c0, c1, c2, c3);
    chk("R7 long frame continues after write", 32'(slot_idx), 2);
    run_ticks(1, c0, c1, c2, c3);
    run_ticks(8, c0, c1, c2, c3);
    chk("R8 short t0", 32'(c0), 4);
    chk("R8 short t1", 32'(c1), 4);
    chk("R6 short t2", 32'(c2), 0);
    chk("R6 short t3", 32'(c3), 0);

    // R4 value captured at the granting edge
    tmr_vals[15:0] = 16'h1234;
    run_ticks(1, c0, c1, c2, c3);
    chk("R4 new timer value", 32'(bus_val), 32'h1234);

    // R1 mid-run reset in long mode
    write_mode(8'h01);
    run_ticks(5, c0, c1, c2, c3);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R1 mid slot", 32'(slot_idx), 0);
    chk("R1 mid mode", 32'(mode_rdata), 0);
    chk("R1 mid cnt", 32'(cnt_ok), 0);
    run_ticks(3, c0, c1, c2, c3);
    chk("R1 short frame after reset", 32'(slot_idx), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule